// File: doc/BRIEF.md
# Relocatable Memory Map Decoder

This block turns every 16-bit CPU address into a chip select for one of four on-chip resources (the RAM, the control register block, the ROM and the EEPROM), or into an external bus select when none of them claims it. Where the RAM and the register block sit is set by an 8-bit map register. Its high nibble names the 4 KB page that holds the RAM. Its low nibble names the 4 KB page that holds the register block. The map register is itself one of the registers, at offset 0x3D of the register block.

After reset the map register holds 0x01. This puts the RAM at 0x0000 and the registers at 0x1000. Boot code may rewrite the map register once, and only during the first 64 E-clock pulses after reset. Later writes are dropped, so the layout stays fixed for the rest of the run. Two enable pins can remove the ROM or the EEPROM from the map, and a single-chip mode pin keeps the ROM present whatever its enable pin says.

The address path is purely combinational. The CPU presents one address per E-clock cycle and does not wait, so there is no valid/ready handshake and no back-pressure. Every pin is a plain control or status pin, and a write takes effect on the clock edge where `e_en_i` is high.

Top module: `memmap_decoder`

## Requirements
- R1: After reset the map register holds 0x01. A read at 0x103D returns 0x01, addresses 0x0000 onward select RAM, and addresses 0x1000 onward select the register block.
- R2: RAM is selected only for the first 0x300 bytes of the page named by map bits 7:4. Offset 0x300 of that page is not RAM.
- R3: The register block is selected only for the first 64 bytes of the page named by map bits 3:0. Offset 0x40 of that page is not the register block.
- R4: Exactly one of `sel_o` and `ext_o` is active for every address, using the bit order RAM=bit0, REG=bit1, ROM=bit2, EEPROM=bit3. Where resources overlap, the register block wins over RAM, and RAM wins over ROM and EEPROM.
- R5: Addresses 0xD000–0xFFFF select the ROM when `rom_en_i` is 1 or `single_chip_i` is 1. Otherwise they go to the external bus.
- R6: Addresses 0xB600–0xB7FF select the EEPROM when `ee_en_i` is 1. Otherwise they go to the external bus.
- R7: A write (`wr_i`=1 with `e_en_i`=1) at offset 0x3D of the current register page is loaded into the map register, if it comes within the first 64 E-clock pulses after reset. This includes the 64th pulse. The decode follows the new value from the next cycle on.
- R8: Once one write has been accepted, any later write to the map register is ignored.
- R9: A write that arrives after 64 E-clock pulses have passed since reset is ignored.
- R10: The write window counts only cycles with `e_en_i`=1. Clock cycles with `e_en_i`=0 do not close the window.
- R11: Reset clears both the pulse count and the record of a past write, so the map register can be written again after each reset.
- R12: `rdata_o` carries the map register only while the address is its location. At any other address it reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| e_en_i | input | 1 | E-clock enable pulse: qualifies writes and advances the window count |
| wr_i | input | 1 | 1 = write access, 0 = read |
| addr_i | input | 16 | CPU address |
| wdata_i | input | 8 | CPU write data |
| single_chip_i | input | 1 | 1 = single-chip mode, which keeps the ROM present |
| rom_en_i | input | 1 | 1 = ROM present in the map |
| ee_en_i | input | 1 | 1 = EEPROM present in the map |
| sel_o | output | 4 | One-hot internal select: bit0 RAM, bit1 REG, bit2 ROM, bit3 EEPROM |
| ext_o | output | 1 | External bus select |
| rdata_o | output | 8 | Map register read data |

## Verification
A table of addresses walks each region edge under the default map: the first and last byte of each region and the first byte past it. These vectors show whether an off-by-one fault lies in the RAM limit, the register limit, or the ROM or EEPROM range. The same ROM and EEPROM addresses are then tried with the enable pins and the mode pin in different states. This separates the enable logic from the range compare.

Directed sequences follow. They relocate both regions to new pages, and then force the RAM and register block onto the same page, and the RAM over the ROM, to expose the priority order. They also write on the 64th and the 65th pulse, and hold `e_en_i` low for many cycles. These show whether the window is counted in E-clock pulses and where exactly it closes.

// File: rtl/memmap_pkg.sv
package memmap_pkg;

  // Bit positions inside the one-hot internal select bus.
  typedef enum int {
    SEL_RAM = 0,
    SEL_REG = 1,
    SEL_ROM = 2,
    SEL_EE  = 3
  } sel_idx_e;

  localparam int NUM_SEL = 4;

  // Request order presented to the priority chain (index 0 wins).
  localparam int PRIO_REG = 0;
  localparam int PRIO_RAM = 1;
  localparam int PRIO_ROM = 2;
  localparam int PRIO_EE  = 3;

endpackage

// File: rtl/mm_page_match.sv
// Hit when the address lies on the given 4 KB-style page and its in-page
// offset is below SPAN bytes.
module mm_page_match #(
  parameter int ADDR_W = 16,
  parameter int PAGE_W = 4,
  parameter int SPAN   = 768
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [PAGE_W-1:0] page_i,
  output logic              hit_o
);
  localparam int OFS_W = ADDR_W - PAGE_W;
  localparam logic [OFS_W:0] LIMIT = (OFS_W+1)'(SPAN);

  logic page_eq;
  logic ofs_in;

  assign page_eq = (addr_i[ADDR_W-1 -: PAGE_W] == page_i);
  assign ofs_in  = ({1'b0, addr_i[OFS_W-1:0]} < LIMIT);
  assign hit_o   = page_eq && ofs_in;
endmodule

// File: rtl/mm_range_match.sv
// Hit when the address lies in the fixed inclusive range [BASE, LAST].
module mm_range_match #(
  parameter int ADDR_W = 16,
  parameter int BASE   = 'hD000,
  parameter int LAST   = 'hFFFF
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic              hit_o
);
  localparam logic [ADDR_W-1:0] LO = ADDR_W'(BASE);
  localparam logic [ADDR_W-1:0] HI = ADDR_W'(LAST);

  assign hit_o = (addr_i >= LO) && (addr_i <= HI);
endmodule

// File: rtl/mm_prio_onehot.sv
// Fixed priority chain: request 0 wins, the grant is one-hot or empty.
module mm_prio_onehot #(
  parameter int N = 4
) (
  input  logic [N-1:0] req_i,
  output logic [N-1:0] gnt_o,
  output logic         none_o
);
  for (genvar i = 0; i < N; i++) begin : g_chain
    if (i == 0) begin : g_first
      assign gnt_o[i] = req_i[i];
    end else begin : g_rest
      assign gnt_o[i] = req_i[i] & ~(|req_i[i-1:0]);
    end
  end
  assign none_o = ~(|req_i);
endmodule

// File: rtl/mm_map_window.sv
// Map register with a one-shot write window counted in E-clock pulses.
module mm_map_window #(
  parameter int             MAP_W     = 8,
  parameter logic [MAP_W-1:0] RESET_VAL = 8'h01,
  parameter int             WINDOW    = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             e_en_i,
  input  logic             wr_req_i,
  input  logic [MAP_W-1:0] wdata_i,
  output logic [MAP_W-1:0] map_o,
  output logic             open_o
);
  localparam int CW = $clog2(WINDOW + 1);
  localparam logic [CW-1:0] LIMIT = CW'(WINDOW);

  logic [CW-1:0]    cnt_q;
  logic             done_q;
  logic [MAP_W-1:0] map_q;
  logic             under;

  assign under  = (cnt_q < LIMIT);
  assign open_o = under && !done_q;
  assign map_o  = map_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      done_q <= 1'b0;
      map_q  <= RESET_VAL;
    end else if (e_en_i) begin
      if (under) begin
        cnt_q <= cnt_q + 1'b1;
      end
      if (wr_req_i && open_o) begin
        map_q  <= wdata_i;
        done_q <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/memmap_decoder.sv
module memmap_decoder
  import memmap_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int PAGE_W    = 4,
  parameter int RAM_BYTES = 768,
  parameter int REG_BYTES = 64,
  parameter int MAP_OFS   = 'h3D,
  parameter int MAP_RESET = 'h01,
  parameter int WINDOW    = 64,
  parameter int ROM_BASE  = 'hD000,
  parameter int ROM_LAST  = 'hFFFF,
  parameter int EE_BASE   = 'hB600,
  parameter int EE_LAST   = 'hB7FF,
  localparam int MAP_W    = 2 * PAGE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              e_en_i,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [MAP_W-1:0]  wdata_i,
  input  logic              single_chip_i,
  input  logic              rom_en_i,
  input  logic              ee_en_i,
  output logic [NUM_SEL-1:0] sel_o,
  output logic              ext_o,
  output logic [MAP_W-1:0]  rdata_o
);
  localparam int REG_OW = $clog2(REG_BYTES);
  localparam logic [REG_OW-1:0] MAP_OFS_L = REG_OW'(MAP_OFS);

  logic [MAP_W-1:0]   map_q;
  logic               win_open;
  logic               ram_hit, reg_hit, rom_range, ee_range;
  logic               map_hit, map_wr;
  logic [NUM_SEL-1:0] req, gnt;
  logic               none;

  // Region matchers: RAM and register block follow the map register.
  mm_page_match #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .SPAN(RAM_BYTES)) u_ram (
    .addr_i(addr_i), .page_i(map_q[MAP_W-1 -: PAGE_W]), .hit_o(ram_hit));

  mm_page_match #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .SPAN(REG_BYTES)) u_reg (
    .addr_i(addr_i), .page_i(map_q[PAGE_W-1:0]), .hit_o(reg_hit));

  mm_range_match #(.ADDR_W(ADDR_W), .BASE(ROM_BASE), .LAST(ROM_LAST)) u_rom (
    .addr_i(addr_i), .hit_o(rom_range));

  mm_range_match #(.ADDR_W(ADDR_W), .BASE(EE_BASE), .LAST(EE_LAST)) u_ee (
    .addr_i(addr_i), .hit_o(ee_range));

  // Map register location and one-shot write.
  assign map_hit = reg_hit && (addr_i[REG_OW-1:0] == MAP_OFS_L);
  assign map_wr  = wr_i && map_hit;

  mm_map_window #(.MAP_W(MAP_W), .RESET_VAL(MAP_W'(MAP_RESET)), .WINDOW(WINDOW)) u_map (
    .clk(clk), .rst_n(rst_n), .e_en_i(e_en_i), .wr_req_i(map_wr),
    .wdata_i(wdata_i), .map_o(map_q), .open_o(win_open));

  // Requests in priority order, then the fixed chain.
  always_comb begin
    req           = '0;
    req[PRIO_REG] = reg_hit;
    req[PRIO_RAM] = ram_hit;
    req[PRIO_ROM] = rom_range && (rom_en_i || single_chip_i);
    req[PRIO_EE]  = ee_range && ee_en_i;
  end

  mm_prio_onehot #(.N(NUM_SEL)) u_arb (.req_i(req), .gnt_o(gnt), .none_o(none));

  always_comb begin
    sel_o          = '0;
    sel_o[SEL_RAM] = gnt[PRIO_RAM];
    sel_o[SEL_REG] = gnt[PRIO_REG];
    sel_o[SEL_ROM] = gnt[PRIO_ROM];
    sel_o[SEL_EE]  = gnt[PRIO_EE];
  end

  assign ext_o   = none;
  assign rdata_o = map_hit ? map_q : '0;
endmodule

// File: rtl/memmap_decoder_chk.sv
module memmap_decoder_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        e_en_i,
  input logic        wr_i,
  input logic [15:0] addr_i,
  input logic        single_chip_i,
  input logic [3:0]  sel_o,
  input logic        ext_o,
  input logic [7:0]  map_q,
  input logic        win_open,
  input logic        map_hit
);
  // R4: one select or the external bus, never two.
  a_r4_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({sel_o, ext_o}) == 1);

  // R1: reset loads the default map.
  a_r1_reset_map: assert property (@(posedge clk)
    !rst_n |=> map_q == 8'h01);

  // R8/R9: a closed window freezes the map.
  a_r9_closed_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !win_open |=> $stable(map_q));

  // R10: no E-clock pulse, no change.
  a_r10_no_pulse_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !e_en_i |=> $stable(map_q));

  // R7: the map changes only after an accepted write at its location.
  a_r7_only_by_write: assert property (@(posedge clk) disable iff (!rst_n)
    !(e_en_i && wr_i && map_hit && win_open) |=> $stable(map_q));

  // R5: single-chip mode keeps ROM unless a higher-priority region claims it.
  a_r5_single_rom: assert property (@(posedge clk) disable iff (!rst_n)
    (single_chip_i && addr_i >= 16'hD000 && !sel_o[0] && !sel_o[1]) |-> sel_o[2]);
endmodule

bind memmap_decoder memmap_decoder_chk chk_i (
  .clk(clk), .rst_n(rst_n), .e_en_i(e_en_i), .wr_i(wr_i), .addr_i(addr_i),
  .single_chip_i(single_chip_i), .sel_o(sel_o), .ext_o(ext_o),
  .map_q(map_q), .win_open(win_open), .map_hit(map_hit));

// File: tb/memmap_decoder_tb_top.sv
module memmap_decoder_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        e_en_i = 1'b0;
  logic        wr_i = 1'b0;
  logic [15:0] addr_i = 16'h5000;
  logic [7:0]  wdata_i = 8'h00;
  logic        single_chip_i = 1'b0;
  logic        rom_en_i = 1'b1;
  logic        ee_en_i = 1'b1;
  logic [3:0]  sel_o;
  logic        ext_o;
  logic [7:0]  rdata_o;

  int total = 0;
  int bad = 0;

  always #4 clk = ~clk;

  memmap_decoder dut_i (
    .clk(clk), .rst_n(rst_n), .e_en_i(e_en_i), .wr_i(wr_i), .addr_i(addr_i),
    .wdata_i(wdata_i), .single_chip_i(single_chip_i), .rom_en_i(rom_en_i),
    .ee_en_i(ee_en_i), .sel_o(sel_o), .ext_o(ext_o), .rdata_o(rdata_o));

  // {req[3:0], addr[15:0], rom_en, ee_en, single, sel[3:0], ext}
  localparam int NV = 13;
  localparam logic [27:0] VEC [NV] = '{
    {4'd2, 16'h0000, 3'b110, 4'b0001, 1'b0},  // R2 first RAM byte
    {4'd2, 16'h02FF, 3'b110, 4'b0001, 1'b0},  // R2 last RAM byte
    {4'd2, 16'h0300, 3'b110, 4'b0000, 1'b1},  // R2 past RAM
    {4'd3, 16'h1000, 3'b110, 4'b0010, 1'b0},  // R3 first register
    {4'd3, 16'h103F, 3'b110, 4'b0010, 1'b0},  // R3 last register
    {4'd3, 16'h1040, 3'b110, 4'b0000, 1'b1},  // R3 past registers
    {4'd5, 16'hD000, 3'b100, 4'b0100, 1'b0},  // R5 ROM enabled
    {4'd5, 16'hFFFF, 3'b000, 4'b0000, 1'b1},  // R5 ROM removed
    {4'd5, 16'hFFFF, 3'b001, 4'b0100, 1'b0},  // R5 single-chip forces ROM
    {4'd6, 16'hB600, 3'b010, 4'b1000, 1'b0},  // R6 EEPROM present
    {4'd6, 16'hB7FF, 3'b100, 4'b0000, 1'b1},  // R6 EEPROM removed
    {4'd6, 16'hB800, 3'b010, 4'b0000, 1'b1},  // R6 past EEPROM
    {4'd4, 16'h5000, 3'b111, 4'b0000, 1'b1}   // R4 unclaimed goes external
  };

  task automatic chk(input string req, input string what, input int got, input int exp);
    total++;
    if (got != exp) begin
      bad++;
      $display("FAIL %s %s: got 0x%0h expected 0x%0h", req, what, got, exp);
    end
  endtask

  task automatic look(input logic [15:0] a);
    @(negedge clk);
    addr_i = a;
    #1;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; e_en_i = 1'b0; wr_i = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic pulses(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      addr_i = 16'h5000; wr_i = 1'b0; e_en_i = 1'b1;
    end
    @(negedge clk);
    e_en_i = 1'b0;
  endtask

  task automatic wr_map(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    addr_i = a; wdata_i = d; wr_i = 1'b1; e_en_i = 1'b1;
    @(negedge clk);
    wr_i = 1'b0; e_en_i = 1'b0; addr_i = 16'h5000;
  endtask

  initial begin
    #(8 * 200000);
    bad++; total++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    do_reset();
    // R1 reset state
    look(16'h103D);
    chk("R1", "reset map read", rdata_o, 8'h01);
    chk("R1", "reset map select", sel_o, 4'b0010);
    look(16'h103C);
    chk("R12", "rdata off map", rdata_o, 8'h00);

    for (int v = 0; v < NV; v++) begin
      @(negedge clk);
      addr_i = VEC[v][23:8];
      {rom_en_i, ee_en_i, single_chip_i} = VEC[v][7:5];
      #1;
      chk($sformatf("R%0d", VEC[v][27:24]), $sformatf("vector %0d sel", v), sel_o, VEC[v][4:1]);
      chk($sformatf("R%0d", VEC[v][27:24]), $sformatf("vector %0d ext", v), ext_o, VEC[v][0]);
    end
    rom_en_i = 1'b1; ee_en_i = 1'b1; single_chip_i = 1'b0;

    // R10: idle clocks without pulses keep the window open; R7 relocate
    repeat (150) @(negedge clk);
    wr_map(16'h103D, 8'h23);
    look(16'h303D);
    chk("R7", "relocated map read", rdata_o, 8'h23);
    chk("R10", "write after idle clocks", rdata_o, 8'h23);
    look(16'h2000);
    chk("R7", "RAM on new page", sel_o, 4'b0001);
    look(16'h3010);
    chk("R7", "registers on new page", sel_o, 4'b0010);
    look(16'h1000);
    chk("R7", "old register page external", ext_o, 1);
    // R8 second write ignored
    wr_map(16'h303D, 8'h45);
    look(16'h303D);
    chk("R8", "second write ignored", rdata_o, 8'h23);

    // R11 reset rearms; R4 register over RAM on a shared page
    do_reset();
    wr_map(16'h103D, 8'h00);
    look(16'h003D);
    chk("R11", "write after re-reset", rdata_o, 8'h00);
    look(16'h0010);
    chk("R4", "register beats RAM", sel_o, 4'b0010);
    look(16'h0100);
    chk("R4", "RAM beyond registers", sel_o, 4'b0001);

    // R4 RAM over ROM
    do_reset();
    wr_map(16'h103D, 8'hD1);
    look(16'hD000);
    chk("R4", "RAM beats ROM", sel_o, 4'b0001);
    look(16'hD300);
    chk("R4", "ROM past RAM", sel_o, 4'b0100);

    // R7 write on the 64th pulse accepted
    do_reset();
    pulses(63);
    wr_map(16'h103D, 8'h71);
    look(16'h103D);
    chk("R7", "write on 64th pulse", rdata_o, 8'h71);

    // R9 write on the 65th pulse ignored
    do_reset();
    pulses(64);
    wr_map(16'h103D, 8'h55);
    look(16'h103D);
    chk("R9", "write after window", rdata_o, 8'h01);
    look(16'h503D);
    chk("R9", "no relocation after window", ext_o, 1);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule